// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block performs trap entry for a processor core with machine, supervisor and user privilege. Each cycle it can accept one trap: a synchronous exception or an interrupt. The trap comes with a cause code, a faulting address, the PC and privilege of the instruction being trapped, and the current interrupt-enable state. The block picks the level that handles the trap from the two delegation masks. On the next clock edge it updates the trap registers of that level: cause, exception PC and trap value. It also updates the status enable, previous-enable and previous-privilege fields, and it produces the handler PC and the new privilege.

Before delegation is decided, the block rewrites an environment call to the variant that matches the current privilege. A trap value is recorded only for causes that carry an address. Handler addresses use the vectored form only for interrupts. Every accepted trap also sends a one-cycle pulse that invalidates the load reservation.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A trap is handled at supervisor level (new privilege 1) only when the current privilege is user (0) or supervisor (1), the effective cause is below 32, and the effective cause's bit is set in the delegation mask. That mask is `ideleg_i` for interrupts and `edeleg_i` for exceptions. Every other trap is handled at machine level (new privilege 3).
- R2: On a supervisor-level trap, `st_spie_o` takes `st_sie_i`, `st_spp_o` is 1 exactly when the current privilege is supervisor, and `st_sie_o` becomes 0. The machine fields take their inputs unchanged.
- R3: On a machine-level trap, `st_mpie_o` takes `st_mie_i`, `st_mpp_o` takes the current privilege, and `st_mie_o` becomes 0. The supervisor fields take their inputs unchanged.
- R4: The cause register of the handling level receives the effective cause in bits 4:0 and the interrupt flag in bit 31, with bits 30:5 zero. The registers of the other level keep their values.
- R5: The exception-PC register of the handling level receives `cur_pc_i`.
- R6: The new PC is the handling level's vector register with bits 1:0 cleared. When the trap is an interrupt and the vector register's bits 1:0 equal 1, the effective cause times 4 is added.
- R7: The trap-value register of the handling level receives `trap_addr_i` for exceptions with causes 0, 1, 4, 5, 6, 7, 12, 13 and 15, and receives zero for every other exception and for all interrupts.
- R8: An exception with cause 8 becomes cause 8, 9 or 11 when the current privilege is user (0), supervisor (1) or machine (3). This rewrite happens before delegation. Interrupt cause 8 is not rewritten.
- R9: `priv_o` becomes 1 or 3 on the edge that accepts the trap.
- R10: `resv_clr_o` is high for exactly the one cycle after each accepted trap, and low otherwise.
- R11: While `trap_vld_i` is low, no output changes, whatever the other inputs do.
- R12: After reset, `priv_o` is 3, `pc_o` is RESET_PC (0x1000), the trap registers and status outputs are zero, and `resv_clr_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_vld_i | input | 1 | One-cycle trap strobe |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause_i | input | 5 | Raw cause code |
| trap_addr_i | input | 32 | Faulting address |
| cur_pc_i | input | 32 | PC of the trapped instruction |
| cur_priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| st_mie_i | input | 1 | Current machine interrupt enable |
| st_sie_i | input | 1 | Current supervisor interrupt enable |
| st_mpie_i | input | 1 | Current machine previous enable |
| st_spie_i | input | 1 | Current supervisor previous enable |
| st_mpp_i | input | 2 | Current machine previous privilege |
| st_spp_i | input | 1 | Current supervisor previous privilege |
| edeleg_i | input | 32 | Exception delegation mask |
| ideleg_i | input | 32 | Interrupt delegation mask |
| mvec_i | input | 32 | Machine vector register (bits 1:0 mode) |
| svec_i | input | 32 | Supervisor vector register (bits 1:0 mode) |
| st_mie_o | output | 1 | Updated machine interrupt enable |
| st_sie_o | output | 1 | Updated supervisor interrupt enable |
| st_mpie_o | output | 1 | Updated machine previous enable |
| st_spie_o | output | 1 | Updated supervisor previous enable |
| st_mpp_o | output | 2 | Updated machine previous privilege |
| st_spp_o | output | 1 | Updated supervisor previous privilege |
| mcause_o | output | 32 | Machine cause register |
| mepc_o | output | 32 | Machine exception PC |
| mtval_o | output | 32 | Machine trap value |
| scause_o | output | 32 | Supervisor cause register |
| sepc_o | output | 32 | Supervisor exception PC |
| stval_o | output | 32 | Supervisor trap value |
| pc_o | output | 32 | Handler PC |
| priv_o | output | 2 | New privilege |
| resv_clr_o | output | 1 | Load-reservation invalidate pulse |

## Verification
The assertions check these properties on every cycle:
- the new privilege is always a legal level;
- a trap from machine privilege never leaves machine level;
- the handling level's enable bit is cleared;
- an exception handler PC is word-aligned;
- the reservation pulse lasts exactly one cycle;
- outputs hold while no trap is presented.

The exact delegation outcome per cause and mask, the environment-call remapping, the trap-value cause set, the vectored offset, and the fact that the other level's registers are left untouched all depend on data values. Only the bench scenarios can show those, by comparing every output against a model computed from the requirements.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int XLEN    = 32;
  localparam int CAUSE_W = 5;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;

  localparam logic [CAUSE_W-1:0] EC_CALL_U = 5'd8;
  localparam logic [CAUSE_W-1:0] EC_CALL_S = 5'd9;
  localparam logic [CAUSE_W-1:0] EC_CALL_M = 5'd11;

  // Exception codes whose trap value is the faulting address
  function automatic logic carries_addr(input logic [CAUSE_W-1:0] c);
    case (c)
      5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15: carries_addr = 1'b1;
      default: carries_addr = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_entry_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int CW = CAUSE_W
) (
  input  logic          irq_i,
  input  logic [CW-1:0] cause_i,
  input  logic [1:0]    priv_i,
  input  logic [W-1:0]  edeleg_i,
  input  logic [W-1:0]  ideleg_i,
  output logic [CW-1:0] cause_o,
  output logic          to_s_o
);
  logic [W-1:0] mask;
  logic         in_range;
  logic         bit_set;

  always_comb begin
    cause_o = cause_i;
    if (!irq_i && cause_i == EC_CALL_U) begin
      case (lvl_e'(priv_i))
        LVL_MACH:  cause_o = EC_CALL_M;
        LVL_SUPER: cause_o = EC_CALL_S;
        default:   cause_o = EC_CALL_U;
      endcase
    end
  end

  generate
    if ((2 ** CW) > W) begin : g_range_chk
      assign in_range = (int'(cause_o) < W);
    end else begin : g_range_full
      assign in_range = 1'b1;
    end
  endgenerate

  assign mask    = irq_i ? ideleg_i : edeleg_i;
  assign bit_set = mask[cause_o];
  assign to_s_o  = (priv_i == LVL_USER || priv_i == LVL_SUPER) && in_range && bit_set;
endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_entry_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int CW = CAUSE_W
) (
  input  logic          irq_i,
  input  logic [CW-1:0] cause_i,
  input  logic [W-1:0]  addr_i,
  input  logic [W-1:0]  vec_i,
  output logic [W-1:0]  pc_o,
  output logic [W-1:0]  tval_o
);
  localparam int PAD = W - CW - 2;
  logic [W-1:0] offs;

  assign offs   = (irq_i && vec_i[1:0] == 2'b01) ? {{PAD{1'b0}}, cause_i, 2'b00} : '0;
  assign pc_o   = {vec_i[W-1:2], 2'b00} + offs;
  assign tval_o = (!irq_i && carries_addr(cause_i)) ? addr_i : '0;
endmodule

// File: rtl/trap_bank.sv
module trap_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] cause_d,
  input  logic [W-1:0] epc_d,
  input  logic [W-1:0] tval_d,
  output logic [W-1:0] cause_q,
  output logic [W-1:0] epc_q,
  output logic [W-1:0] tval_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
      tval_q  <= '0;
    end else if (we_i) begin
      cause_q <= cause_d;
      epc_q   <= epc_d;
      tval_q  <= tval_d;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int          W        = XLEN,
  parameter int          CW       = CAUSE_W,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trap_vld_i,
  input  logic          trap_irq_i,
  input  logic [CW-1:0] trap_cause_i,
  input  logic [W-1:0]  trap_addr_i,
  input  logic [W-1:0]  cur_pc_i,
  input  logic [1:0]    cur_priv_i,
  input  logic          st_mie_i,
  input  logic          st_sie_i,
  input  logic          st_mpie_i,
  input  logic          st_spie_i,
  input  logic [1:0]    st_mpp_i,
  input  logic          st_spp_i,
  input  logic [W-1:0]  edeleg_i,
  input  logic [W-1:0]  ideleg_i,
  input  logic [W-1:0]  mvec_i,
  input  logic [W-1:0]  svec_i,
  output logic          st_mie_o,
  output logic          st_sie_o,
  output logic          st_mpie_o,
  output logic          st_spie_o,
  output logic [1:0]    st_mpp_o,
  output logic          st_spp_o,
  output logic [W-1:0]  mcause_o,
  output logic [W-1:0]  mepc_o,
  output logic [W-1:0]  mtval_o,
  output logic [W-1:0]  scause_o,
  output logic [W-1:0]  sepc_o,
  output logic [W-1:0]  stval_o,
  output logic [W-1:0]  pc_o,
  output logic [1:0]    priv_o,
  output logic          resv_clr_o
);
  localparam int NLVL = 2;   // bank 0 = machine, bank 1 = supervisor
  localparam int ZW   = W - CW - 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [CW-1:0] eff_cause;
  logic          to_s;
  logic [W-1:0]  vec_sel, pc_d, tval_d, cause_d;

  trap_route #(.W(W), .CW(CW)) u_route (
    .irq_i   (trap_irq_i),
    .cause_i (trap_cause_i),
    .priv_i  (cur_priv_i),
    .edeleg_i(edeleg_i),
    .ideleg_i(ideleg_i),
    .cause_o (eff_cause),
    .to_s_o  (to_s)
  );

  assign vec_sel = to_s ? svec_i : mvec_i;
  assign cause_d = {trap_irq_i, {ZW{1'b0}}, eff_cause};

  trap_target #(.W(W), .CW(CW)) u_target (
    .irq_i  (trap_irq_i),
    .cause_i(eff_cause),
    .addr_i (trap_addr_i),
    .vec_i  (vec_sel),
    .pc_o   (pc_d),
    .tval_o (tval_d)
  );

  logic [W-1:0] bk_cause [NLVL];
  logic [W-1:0] bk_epc   [NLVL];
  logic [W-1:0] bk_tval  [NLVL];

  for (genvar l = 0; l < NLVL; l++) begin : g_bank
    logic we;
    assign we = trap_vld_i && (to_s == (l == 1));
    trap_bank #(.W(W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .we_i   (we),
      .cause_d(cause_d),
      .epc_d  (cur_pc_i),
      .tval_d (tval_d),
      .cause_q(bk_cause[l]),
      .epc_q  (bk_epc[l]),
      .tval_q (bk_tval[l])
    );
  end

  assign mcause_o = bk_cause[0];
  assign mepc_o   = bk_epc[0];
  assign mtval_o  = bk_tval[0];
  assign scause_o = bk_cause[1];
  assign sepc_o   = bk_epc[1];
  assign stval_o  = bk_tval[1];

  // status next-state
  logic       mie_d, sie_d, mpie_d, spie_d, spp_d;
  logic [1:0] mpp_d, priv_d;

  always_comb begin
    mie_d  = st_mie_i;
    sie_d  = st_sie_i;
    mpie_d = st_mpie_i;
    spie_d = st_spie_i;
    mpp_d  = st_mpp_i;
    spp_d  = st_spp_i;
    if (to_s) begin
      spie_d = st_sie_i;
      spp_d  = (cur_priv_i == LVL_SUPER);
      sie_d  = 1'b0;
      priv_d = LVL_SUPER;
    end else begin
      mpie_d = st_mie_i;
      mpp_d  = cur_priv_i;
      mie_d  = 1'b0;
      priv_d = LVL_MACH;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_mie_o  <= 1'b0;
      st_sie_o  <= 1'b0;
      st_mpie_o <= 1'b0;
      st_spie_o <= 1'b0;
      st_mpp_o  <= 2'b00;
      st_spp_o  <= 1'b0;
      pc_o      <= RESET_PC;
      priv_o    <= LVL_MACH;
    end else if (trap_vld_i) begin
      st_mie_o  <= mie_d;
      st_sie_o  <= sie_d;
      st_mpie_o <= mpie_d;
      st_spie_o <= spie_d;
      st_mpp_o  <= mpp_d;
      st_spp_o  <= spp_d;
      pc_o      <= pc_d;
      priv_o    <= priv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) resv_clr_o <= 1'b0;
    else             resv_clr_o <= trap_vld_i;
  end

  AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_vld_i |=> (priv_o == LVL_SUPER || priv_o == LVL_MACH)); // R9
  AST_MACH_STAYS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trap_vld_i && cur_priv_i == LVL_MACH) |=> priv_o == LVL_MACH); // R1
  AST_SIE_CLEARED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trap_vld_i && to_s) |=> !st_sie_o); // R2
  AST_MIE_CLEARED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trap_vld_i && !to_s) |=> !st_mie_o); // R3
  AST_EXC_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trap_vld_i && !trap_irq_i) |=> pc_o[1:0] == 2'b00); // R6
  AST_RESV_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_vld_i |=> resv_clr_o); // R10
  AST_RESV_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !trap_vld_i |=> !resv_clr_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !trap_vld_i |=> ($stable(pc_o) && $stable(priv_o) && $stable(mcause_o) && $stable(scause_o))); // R11
endmodule

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_vld_i = 1'b0, trap_irq_i = 1'b0;
  logic [4:0]  trap_cause_i = '0;
  logic [31:0] trap_addr_i = '0, cur_pc_i = '0;
  logic [1:0]  cur_priv_i = '0;
  logic        st_mie_i = 1'b0, st_sie_i = 1'b0, st_mpie_i = 1'b0, st_spie_i = 1'b0, st_spp_i = 1'b0;
  logic [1:0]  st_mpp_i = '0;
  logic [31:0] edeleg_i = '0, ideleg_i = '0, mvec_i = '0, svec_i = '0;
  logic        st_mie_o, st_sie_o, st_mpie_o, st_spie_o, st_spp_o, resv_clr_o;
  logic [1:0]  st_mpp_o, priv_o;
  logic [31:0] mcause_o, mepc_o, mtval_o, scause_o, sepc_o, stval_o, pc_o;

  always #4 clk = ~clk;  // 125 MHz

  trap_entry_ctrl dut (.*);

  typedef struct {
    logic mie, sie, mpie, spie, spp;
    logic [1:0] mpp, priv;
    logic [31:0] mcause, mepc, mtval, scause, sepc, stval, pc;
  } exp_t;

  exp_t model;
  exp_t q[$];
  int   n_chk = 0, n_err = 0;
  bit   done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all(string req, exp_t e);
    chk("R2", {req, " sie"},  st_sie_o,  e.sie);
    chk("R2", {req, " spie"}, st_spie_o, e.spie);
    chk("R2", {req, " spp"},  st_spp_o,  e.spp);
    chk("R3", {req, " mie"},  st_mie_o,  e.mie);
    chk("R3", {req, " mpie"}, st_mpie_o, e.mpie);
    chk("R3", {req, " mpp"},  st_mpp_o,  e.mpp);
    chk("R4", {req, " mcause"}, mcause_o, e.mcause);
    chk("R4", {req, " scause"}, scause_o, e.scause);
    chk("R5", {req, " mepc"}, mepc_o, e.mepc);
    chk("R5", {req, " sepc"}, sepc_o, e.sepc);
    chk("R7", {req, " mtval"}, mtval_o, e.mtval);
    chk("R7", {req, " stval"}, stval_o, e.stval);
    chk("R6", {req, " pc"}, pc_o, e.pc);
    chk("R9", {req, " priv"}, priv_o, e.priv);
  endtask

  // driver: computes the expected result from the requirements and pushes it
  task automatic do_trap(logic irq, logic [4:0] cause, logic [31:0] addr, logic [31:0] pc,
                         logic [1:0] priv, logic [3:0] en, logic [31:0] ed, logic [31:0] id,
                         logic [31:0] mv, logic [31:0] sv);
    logic [4:0] c;
    logic to_s, tv_ok;
    logic [31:0] vec, cv, tv, mask;
    c = cause;
    if (!irq && cause == 5'd8) c = (priv == 2'd3) ? 5'd11 : (priv == 2'd1) ? 5'd9 : 5'd8; // R8
    mask = irq ? id : ed;
    to_s = (priv <= 2'd1) && mask[c];  // R1
    tv_ok = !irq && (c inside {5'd0, 5'd1, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15});
    tv = tv_ok ? addr : 32'd0;
    cv = {irq, 26'd0, c};
    vec = to_s ? sv : mv;
    model.mie = en[3]; model.sie = en[2]; model.mpie = en[1]; model.spie = en[0];
    model.mpp = 2'b10; model.spp = 1'b1;
    if (to_s) begin
      model.spie = en[2]; model.spp = (priv == 2'd1); model.sie = 1'b0; model.priv = 2'd1;
      model.scause = cv; model.sepc = pc; model.stval = tv;
    end else begin
      model.mpie = en[3]; model.mpp = priv; model.mie = 1'b0; model.priv = 2'd3;
      model.mcause = cv; model.mepc = pc; model.mtval = tv;
    end
    model.pc = {vec[31:2], 2'b00} + ((irq && vec[1:0] == 2'b01) ? {25'd0, c, 2'b00} : 32'd0);
    q.push_back(model);
    @(negedge clk);
    trap_vld_i = 1'b1; trap_irq_i = irq; trap_cause_i = cause; trap_addr_i = addr;
    cur_pc_i = pc; cur_priv_i = priv;
    {st_mie_i, st_sie_i, st_mpie_i, st_spie_i} = en;
    st_mpp_i = 2'b10; st_spp_i = 1'b1;
    edeleg_i = ed; ideleg_i = id; mvec_i = mv; svec_i = sv;
    @(negedge clk);
    trap_vld_i = 1'b0;
  endtask

  // monitor: pops the expected item after the accepting edge
  initial begin
    forever begin
      @(posedge clk);
      if (trap_vld_i) begin
        #2;
        if (q.size() == 0) chk("R11", "unexpected trap", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          cmp_all("trap", e);
          chk("R10", "resv pulse", {31'd0, resv_clr_o}, 32'd1);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    if (!done) begin
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    model = '{mie:0, sie:0, mpie:0, spie:0, spp:0, mpp:0, priv:2'd3,
              mcause:0, mepc:0, mtval:0, scause:0, sepc:0, stval:0, pc:32'h1000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_all("R12 reset", model);
    chk("R12", "reset resv", {31'd0, resv_clr_o}, 32'd0);

    // R8 R1: U ecall not delegated -> M, cause 8
    do_trap(0, 5'd8, 32'hDEAD0000, 32'h100, 2'd0, 4'b1111, 32'h0, 32'h0, 32'h8000_0000, 32'h4000_0000);
    // R8: U ecall delegated -> S, cause 8
    do_trap(0, 5'd8, 32'h0, 32'h104, 2'd0, 4'b1100, 32'h100, 32'h0, 32'h8000_0000, 32'h4000_0001);
    // R8: S ecall, bit 9 delegated -> S, cause 9
    do_trap(0, 5'd8, 32'h0, 32'h108, 2'd1, 4'b0100, 32'h200, 32'h0, 32'h8000_0000, 32'h4000_0000);
    // R1 R8: M ecall with bit 11 set -> stays M, cause 11
    do_trap(0, 5'd8, 32'h0, 32'h10C, 2'd3, 4'b1000, 32'hFFFF_FFFF, 32'h0, 32'h8000_0003, 32'h4000_0000);
    // R7: load page fault from S delegated -> S, tval = addr
    do_trap(0, 5'd13, 32'hCAFE_F00D, 32'h110, 2'd1, 4'b0111, 32'h2000, 32'h0, 32'h8000_0000, 32'h4000_0100);
    // R7: illegal instruction -> tval 0
    do_trap(0, 5'd2, 32'h1234_5678, 32'h114, 2'd0, 4'b1010, 32'h0, 32'h0, 32'h8000_0001, 32'h4000_0000);
    // R7: store access fault -> M tval = addr
    do_trap(0, 5'd7, 32'h5555_AAAA, 32'h118, 2'd0, 4'b1001, 32'h0, 32'h0, 32'h8000_0000, 32'h4000_0000);
    // R6: delegated interrupt 5, vectored S -> base + 20
    do_trap(1, 5'd5, 32'hFFFF_0000, 32'h11C, 2'd0, 4'b0110, 32'h0, 32'h20, 32'h8000_0000, 32'h4000_0201);
    // R6: interrupt 7 vectored M -> base + 28, tval 0
    do_trap(1, 5'd7, 32'hFFFF_0000, 32'h120, 2'd1, 4'b1111, 32'h0, 32'h0, 32'h8000_0401, 32'h4000_0000);
    // R6: interrupt with mode 0 -> no offset
    do_trap(1, 5'd11, 32'h0, 32'h124, 2'd0, 4'b1000, 32'h0, 32'h0, 32'h8000_0800, 32'h4000_0000);
    // R1: interrupt 9, mask select: edeleg bit set, ideleg clear -> M
    do_trap(1, 5'd9, 32'h0, 32'h128, 2'd1, 4'b1100, 32'h200, 32'h0, 32'h8000_0000, 32'h4000_0001);
    // R8: interrupt 8 not remapped, delegated via bit 8
    do_trap(1, 5'd8, 32'h0, 32'h12C, 2'd1, 4'b0100, 32'h0, 32'h100, 32'h8000_0000, 32'h4000_0001);

    // R11 R10: idle cycles with busy inputs change nothing
    @(negedge clk);
    trap_cause_i = 5'd3; cur_pc_i = 32'hFFFF_FFFF; cur_priv_i = 2'd0; edeleg_i = '1;
    st_mie_i = 1'b1; st_sie_i = 1'b1; mvec_i = 32'h1; svec_i = 32'h2;
    repeat (3) @(negedge clk);
    cmp_all("R11 idle", model);
    chk("R10", "resv idle", {31'd0, resv_clr_o}, 32'd0);
    chk("R11", "queue drained", q.size(), 32'd0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule